// File: doc/BRIEF.md
# Dual-Core Lockstep Compare Monitor

This block sits beside a pair of cores that run the same program in lockstep. It watches two pairs of buses. The first pair comes from the main core and the checker core. The second pair comes from their two interrupt controllers. In its default mode it compares each pair on every cycle. A difference sets a sticky error flag. The first newly detected difference also raises a one-cycle event towards the chip's error aggregator. The CPU-pair event is meant to be routed as a high-priority event.

Each pair is a separate diagnostic with its own operating mode. Software selects the mode by writing a 4-bit key value together with a diagnostic select. Out of reset both diagnostics are in lockstep compare. The other modes are temporary:

- A self-test pushes generated patterns through the diagnostic's own comparator, then reports completion and pass/fail.
- A self-test variant corrupts those patterns so that the test must report a failure.
- An error-forcing mode injects exactly one mismatch to exercise the error path.

Each of these modes falls back to lockstep compare on its own when it finishes. While a debug-halt request is active, every diagnostic is frozen: no errors, no flag changes and no self-test progress.

Top module: `lockstep_cmp_mon`

## Requirements
- R1: After reset all error flags, error events, self-test done flags and self-test fail flags are 0, and both diagnostics are in lockstep compare mode.
- R2: Both buses of each pair are registered before comparison. In lockstep mode, a CPU-pair mismatch presented in a cycle with `dbg_halt_i` low sets `err_flag_o[0]` at the second rising edge after it is presented. If the flag was clear, `err_evt_o[0]` is high for exactly that one cycle.
- R3: The interrupt-controller pair is compared independently. Its result is reported on bit 1 of `err_flag_o` and `err_evt_o`, with the same timing as R2.
- R4: Error flags are sticky. While a flag stays set, further mismatches produce no new event, and an event is never high without its flag.
- R5: Writing `clr_wr_i`=1 clears each error flag whose bit is 1 in `clr_mask_i`. If a mismatch is detected on the same edge, the flag stays set and a new event is raised.
- R6: A debug-halt request presented in a cycle suppresses the comparison of the data presented in that same cycle, and also suppresses error forcing and self-test progress. No flag rises and no event is raised. Checking resumes with the first cycle presented with the request low, and the mode is unchanged.
- R7: A key write (`key_wr_i`=1) applies `key_val_i` to the diagnostic chosen by `key_sel_i` (0 = CPU pair, 1 = interrupt-controller pair). The legal values are 0x0 (lockstep compare), 0x6 (self-test), 0x9 (error forcing) and 0xF (self-test with error forcing). Any other value is ignored and leaves the mode unchanged.
- R8: Self-test (0x6) clears that diagnostic's done and fail flags. It then runs for ST_CYC unhalted cycles, during which functional mismatches are ignored. It finally sets `st_done_o` with `st_fail_o` at 0 and returns to lockstep compare.
- R9: Self-test with error forcing (0xF) behaves like R8, except that it ends with both `st_done_o` and `st_fail_o` set for that diagnostic.
- R10: Error forcing (0x9) sets that diagnostic's error flag, with an event if the flag was clear, on the first unhalted edge after the key is accepted. The diagnostic then returns to lockstep compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_main_i | input | CPU_W | Output bus of the main core |
| cpu_chk_i | input | CPU_W | Output bus of the checker core |
| vic_main_i | input | VIC_W | Output bus of the main interrupt controller |
| vic_chk_i | input | VIC_W | Output bus of the checker interrupt controller |
| key_wr_i | input | 1 | Key register write strobe |
| key_sel_i | input | 1 | Target diagnostic: 0 CPU pair, 1 interrupt-controller pair |
| key_val_i | input | 4 | Key value |
| dbg_halt_i | input | 1 | Halting debug request |
| clr_wr_i | input | 1 | Error flag clear strobe |
| clr_mask_i | input | 2 | Write-one-to-clear mask for the error flags |
| err_flag_o | output | 2 | Sticky compare error flags (bit 0 CPU, bit 1 interrupt controller) |
| err_evt_o | output | 2 | One-cycle error events to the error aggregator |
| st_done_o | output | 2 | Self-test completed flags |
| st_fail_o | output | 2 | Self-test failed flags |

## Verification
The compare path is driven in several ways:

- A single-cycle CPU mismatch and a single-cycle interrupt-controller mismatch separate the two lanes and pin down the two-edge latency.
- A mismatch held for several cycles separates sticky flagging from repeated events.
- A held mismatch combined with a clear strobe tells a clear-wins design from a set-wins design.

Mismatches presented during a debug-halt window, including the cycle where the request drops, show whether the halt is paired with the data it arrives with. Self-tests run with functional mismatches on the buses show that functional compare is masked during a test. A test halted partway shows that its cycle count freezes. An illegal key and a key aimed at the other diagnostic separate key decoding from diagnostic selection.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [1:0] {
    M_LOCK   = 2'd0,
    M_TEST   = 2'd1,
    M_FORCE  = 2'd2,
    M_TFORCE = 2'd3
  } mode_t;

  localparam int KEY_W = 4;

  localparam logic [KEY_W-1:0] KEY_LOCK   = 4'h0;
  localparam logic [KEY_W-1:0] KEY_TEST   = 4'h6;
  localparam logic [KEY_W-1:0] KEY_FORCE  = 4'h9;
  localparam logic [KEY_W-1:0] KEY_TFORCE = 4'hF;

  function automatic logic key_legal(input logic [KEY_W-1:0] k);
    return (k == KEY_LOCK) || (k == KEY_TEST) || (k == KEY_FORCE) || (k == KEY_TFORCE);
  endfunction

  function automatic mode_t key_to_mode(input logic [KEY_W-1:0] k);
    mode_t m;
    case (k)
      KEY_TEST:   m = M_TEST;
      KEY_FORCE:  m = M_FORCE;
      KEY_TFORCE: m = M_TFORCE;
      default:    m = M_LOCK;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lsm_eq.sv
module lsm_eq #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         diff_o
);
  assign diff_o = |(a_i ^ b_i);
endmodule

// File: rtl/lsm_diag.sv
module lsm_diag
  import lsm_pkg::*;
#(
  parameter int W      = 32,
  parameter int ST_CYC = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] main_i,
  input  logic [W-1:0] chk_i,
  input  logic         halt_i,
  input  logic         key_hit_i,
  input  mode_t        key_mode_i,
  input  logic         clr_i,
  output logic         flag_o,
  output logic         evt_o,
  output logic         done_o,
  output logic         fail_o,
  output mode_t        mode_o
);
  localparam int CW = (ST_CYC > 1) ? $clog2(ST_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(ST_CYC - 1);

  logic [W-1:0]  main_q, chk_q;
  logic          halt_q;
  mode_t         mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          acc_q, acc_d;
  logic          flag_q, flag_d, evt_q, evt_d;
  logic          done_q, done_d, fail_q, fail_d;

  logic [W-1:0]  pat, cmp_a, cmp_b;
  logic          diff_main, diff_inv;
  logic          run, in_test, at_last, func_mis, st_bad, flag_kept, st_en;

  // pattern generator for the self-test
  assign pat = W'(cnt_q) ^ {W{cnt_q[0]}};

  always_comb begin
    case (mode_q)
      M_FORCE:  begin cmp_a = main_q; cmp_b = main_q ^ W'(1); end
      M_TEST:   begin cmp_a = pat;    cmp_b = pat;           end
      M_TFORCE: begin cmp_a = pat;    cmp_b = pat ^ W'(1);   end
      default:  begin cmp_a = main_q; cmp_b = chk_q;         end
    endcase
  end

  lsm_eq #(.W(W)) u_eq_main (.a_i(cmp_a), .b_i(cmp_b), .diff_o(diff_main));
  lsm_eq #(.W(W)) u_eq_inv  (.a_i(pat),   .b_i(~pat),  .diff_o(diff_inv));

  assign run      = !halt_q;
  assign in_test  = (mode_q == M_TEST) || (mode_q == M_TFORCE);
  assign at_last  = (cnt_q == LAST);
  assign func_mis = run && ((mode_q == M_LOCK) || (mode_q == M_FORCE)) && diff_main;
  assign st_bad   = diff_main | ~diff_inv;
  assign st_en    = key_hit_i || (run && in_test);
  assign flag_kept = flag_q & ~clr_i;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    done_d = done_q;
    fail_d = fail_q;
    if (run && (mode_q == M_FORCE)) mode_d = M_LOCK;
    if (run && in_test) begin
      acc_d = acc_q | st_bad;
      if (at_last) begin
        mode_d = M_LOCK;
        cnt_d  = '0;
        done_d = 1'b1;
        fail_d = acc_q | st_bad;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
    if (key_hit_i) begin
      mode_d = key_mode_i;
      cnt_d  = '0;
      acc_d  = 1'b0;
      if ((key_mode_i == M_TEST) || (key_mode_i == M_TFORCE)) begin
        done_d = 1'b0;
        fail_d = 1'b0;
      end
    end
    flag_d = flag_kept | func_mis;
    evt_d  = func_mis & ~flag_kept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      chk_q  <= '0;
      halt_q <= 1'b0;
      mode_q <= M_LOCK;
      cnt_q  <= '0;
      acc_q  <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      flag_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      main_q <= main_i;
      chk_q  <= chk_i;
      halt_q <= halt_i;
      mode_q <= mode_d;
      flag_q <= flag_d;
      evt_q  <= evt_d;
      if (st_en) begin
        cnt_q  <= cnt_d;
        acc_q  <= acc_d;
        done_q <= done_d;
        fail_q <= fail_d;
      end
    end
  end

  assign flag_o = flag_q;
  assign evt_o  = evt_q;
  assign done_o = done_q;
  assign fail_o = fail_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/lockstep_cmp_mon.sv
module lockstep_cmp_mon
  import lsm_pkg::*;
#(
  parameter int CPU_W  = 32,
  parameter int VIC_W  = 16,
  parameter int ST_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CPU_W-1:0] cpu_main_i,
  input  logic [CPU_W-1:0] cpu_chk_i,
  input  logic [VIC_W-1:0] vic_main_i,
  input  logic [VIC_W-1:0] vic_chk_i,
  input  logic             key_wr_i,
  input  logic             key_sel_i,
  input  logic [3:0]       key_val_i,
  input  logic             dbg_halt_i,
  input  logic             clr_wr_i,
  input  logic [1:0]       clr_mask_i,
  output logic [1:0]       err_flag_o,
  output logic [1:0]       err_evt_o,
  output logic [1:0]       st_done_o,
  output logic [1:0]       st_fail_o
);
  localparam int NDIAG = 2;

  logic                  key_ok;
  mode_t                 key_mode;
  logic [NDIAG-1:0]      key_hit;
  logic [NDIAG-1:0]      clr_hit;
  mode_t [NDIAG-1:0]     diag_mode;

  assign key_ok   = key_legal(key_val_i);
  assign key_mode = key_to_mode(key_val_i);

  for (genvar g = 0; g < NDIAG; g++) begin : g_diag
    assign key_hit[g] = key_wr_i && key_ok && (key_sel_i == g[0]);
    assign clr_hit[g] = clr_wr_i && clr_mask_i[g];
    if (g == 0) begin : g_cpu
      lsm_diag #(.W(CPU_W), .ST_CYC(ST_CYC)) u_diag (
        .clk(clk), .rst_n(rst_n),
        .main_i(cpu_main_i), .chk_i(cpu_chk_i), .halt_i(dbg_halt_i),
        .key_hit_i(key_hit[g]), .key_mode_i(key_mode), .clr_i(clr_hit[g]),
        .flag_o(err_flag_o[g]), .evt_o(err_evt_o[g]),
        .done_o(st_done_o[g]), .fail_o(st_fail_o[g]), .mode_o(diag_mode[g])
      );
    end else begin : g_vic
      lsm_diag #(.W(VIC_W), .ST_CYC(ST_CYC)) u_diag (
        .clk(clk), .rst_n(rst_n),
        .main_i(vic_main_i), .chk_i(vic_chk_i), .halt_i(dbg_halt_i),
        .key_hit_i(key_hit[g]), .key_mode_i(key_mode), .clr_i(clr_hit[g]),
        .flag_o(err_flag_o[g]), .evt_o(err_evt_o[g]),
        .done_o(st_done_o[g]), .fail_o(st_fail_o[g]), .mode_o(diag_mode[g])
      );
    end
  end
endmodule

// File: rtl/lsm_chk.sv
module lsm_chk
  import lsm_pkg::*;
#(
  parameter int CPU_W = 32,
  parameter int VIC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CPU_W-1:0] cpu_main_i,
  input logic [CPU_W-1:0] cpu_chk_i,
  input logic [VIC_W-1:0] vic_main_i,
  input logic [VIC_W-1:0] vic_chk_i,
  input logic             key_wr_i,
  input logic [3:0]       key_val_i,
  input logic             dbg_halt_i,
  input logic [1:0]       err_flag_o,
  input logic [1:0]       err_evt_o,
  input logic [1:0]       st_done_o,
  input mode_t [1:0]      mode_i
);
  logic cpu_mis, vic_mis;
  assign cpu_mis = cpu_main_i != cpu_chk_i;
  assign vic_mis = vic_main_i != vic_chk_i;

  AST_EVT_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt_o & ~err_flag_o) == 2'b00); // R4

  AST_CPU_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_mis && !dbg_halt_i) && mode_i[0] == M_LOCK) |=> err_flag_o[0]); // R2

  AST_VIC_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vic_mis && !dbg_halt_i) && mode_i[1] == M_LOCK) |=> err_flag_o[1]); // R3

  AST_HALT_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dbg_halt_i) |=> (!$rose(err_flag_o[0]) && !$rose(err_flag_o[1]) && err_evt_o == 2'b00)); // R6

  AST_HALT_NO_TEST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dbg_halt_i) |=> (!$rose(st_done_o[0]) && !$rose(st_done_o[1]))); // R6

  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr_i && !key_legal(key_val_i) && mode_i[0] == M_LOCK && mode_i[1] == M_LOCK)
      |=> (mode_i[0] == M_LOCK && mode_i[1] == M_LOCK)); // R7

  AST_FORCE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[0] == M_FORCE && !$past(dbg_halt_i)) |=> err_flag_o[0]); // R10
endmodule

bind lockstep_cmp_mon lsm_chk #(.CPU_W(CPU_W), .VIC_W(VIC_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_main_i(cpu_main_i), .cpu_chk_i(cpu_chk_i),
  .vic_main_i(vic_main_i), .vic_chk_i(vic_chk_i),
  .key_wr_i(key_wr_i), .key_val_i(key_val_i), .dbg_halt_i(dbg_halt_i),
  .err_flag_o(err_flag_o), .err_evt_o(err_evt_o), .st_done_o(st_done_o),
  .mode_i(diag_mode)
);

// File: tb/sim_lockstep_cmp_mon.sv
`timescale 1ns/1ps
module sim_lockstep_cmp_mon;
  localparam logic [31:0] A = 32'hA5C3_0F17;
  localparam logic [15:0] B = 16'h3C5A;

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] cpu_m, cpu_c;
  logic [15:0] vic_m, vic_c;
  logic key_wr, key_sel, halt, clr_wr;
  logic [3:0] key_val;
  logic [1:0] clr_mask, err_flag, err_evt, st_done, st_fail;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  lockstep_cmp_mon u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_main_i(cpu_m), .cpu_chk_i(cpu_c), .vic_main_i(vic_m), .vic_chk_i(vic_c),
    .key_wr_i(key_wr), .key_sel_i(key_sel), .key_val_i(key_val), .dbg_halt_i(halt),
    .clr_wr_i(clr_wr), .clr_mask_i(clr_mask),
    .err_flag_o(err_flag), .err_evt_o(err_evt), .st_done_o(st_done), .st_fail_o(st_fail)
  );

  // monitor: compare outputs after each rising edge with the queued expectation
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      logic [7:0] g;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = {err_flag, err_evt, st_done, st_fail};
      nchk++;
      if (g !== e) begin
        nerr++;
        $display("FAIL %s flag/evt/done/fail actual=%b expected=%b", t, g, e);
      end
    end
  end

  // driver: inputs already set; queue expectation for the coming edge
  task automatic tick(input logic [1:0] f, input logic [1:0] ev,
                      input logic [1:0] d, input logic [1:0] x, input string t);
    exp_q.push_back({f, ev, d, x});
    tag_q.push_back(t);
    @(negedge clk);
    #1;
  endtask

  task automatic key(input logic s, input logic [3:0] v);
    key_wr = 1'b1; key_sel = s; key_val = v;
  endtask

  task automatic idle();
    key_wr = 1'b0; clr_wr = 1'b0; clr_mask = 2'b00; halt = 1'b0;
    cpu_c = cpu_m; vic_c = vic_m;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cpu_m = A; vic_m = B; key_val = 4'h0; key_sel = 1'b0;
    idle();
    @(negedge clk); #1;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R1 in reset");
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R1 in reset");
    rst_n = 1'b1;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R1 after release");

    // single CPU mismatch
    cpu_c = A ^ 32'h1;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R2 input registered");
    idle();
    tick(2'b01, 2'b01, 2'b00, 2'b00, "R2 flag and event");
    tick(2'b01, 2'b00, 2'b00, 2'b00, "R4 event one cycle");

    // persistent mismatch while flag set
    cpu_c = A ^ 32'h8000_0000;
    tick(2'b01, 2'b00, 2'b00, 2'b00, "R4 no new event");
    tick(2'b01, 2'b00, 2'b00, 2'b00, "R4 no new event");
    idle();
    tick(2'b01, 2'b00, 2'b00, 2'b00, "R4 sticky");

    // clear
    clr_wr = 1'b1; clr_mask = 2'b01;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R5 clear");
    idle();

    // clear while mismatch persists
    cpu_c = ~A;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R5 setup");
    clr_wr = 1'b1; clr_mask = 2'b01;
    tick(2'b01, 2'b01, 2'b00, 2'b00, "R5 first set");
    tick(2'b01, 2'b01, 2'b00, 2'b00, "R5 set beats clear, new event");
    idle();
    tick(2'b01, 2'b00, 2'b00, 2'b00, "R5 stays set");
    tick(2'b01, 2'b00, 2'b00, 2'b00, "R5 stays set");
    clr_wr = 1'b1; clr_mask = 2'b11;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R5 clear");
    idle();

    // interrupt-controller pair
    vic_c = B ^ 16'h0080;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R3 input registered");
    idle();
    tick(2'b10, 2'b10, 2'b00, 2'b00, "R3 lane 1 only");
    tick(2'b10, 2'b00, 2'b00, 2'b00, "R3 sticky");
    clr_wr = 1'b1; clr_mask = 2'b10;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R5 clear lane 1");
    idle();

    // debug halt
    halt = 1'b1; cpu_c = A ^ 32'h10;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R6 halted");
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R6 halted mismatch ignored");
    idle();
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R6 halted data still ignored");
    cpu_c = A ^ 32'h10;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R6 resume");
    idle();
    tick(2'b01, 2'b01, 2'b00, 2'b00, "R6 checking resumed");
    clr_wr = 1'b1; clr_mask = 2'b01;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R5 clear");
    idle();

    // illegal key: mode must stay lockstep
    key(1'b0, 4'h3);
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R7 illegal key");
    idle();
    cpu_c = A ^ 32'h4;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R7 illegal key");
    idle();
    tick(2'b01, 2'b01, 2'b00, 2'b00, "R7 still lockstep");
    clr_wr = 1'b1; clr_mask = 2'b01;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R5 clear");
    idle();

    // error forcing on interrupt-controller lane
    key(1'b1, 4'h9);
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R10 key accepted");
    idle();
    tick(2'b10, 2'b10, 2'b00, 2'b00, "R10 forced error, R7 lane select");
    tick(2'b10, 2'b00, 2'b00, 2'b00, "R10 back to lockstep");
    clr_wr = 1'b1; clr_mask = 2'b10;
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R5 clear");
    idle();

    // self-test on CPU lane with functional mismatch present
    key(1'b0, 4'h6);
    tick(2'b00, 2'b00, 2'b00, 2'b00, "R8 key accepted");
    idle();
    cpu_c = ~A;
    for (int i = 0; i < 7; i++) tick(2'b00, 2'b00, 2'b00, 2'b00, "R8 running, mismatch masked");
    idle();
    tick(2'b00, 2'b00, 2'b01, 2'b00, "R8 done pass");
    tick(2'b00, 2'b00, 2'b01, 2'b00, "R8 lockstep equal");
    cpu_c = A ^ 32'h2;
    tick(2'b00, 2'b00, 2'b01, 2'b00, "R8 lockstep");
    idle();
    tick(2'b01, 2'b01, 2'b01, 2'b00, "R8 back to lockstep");
    clr_wr = 1'b1; clr_mask = 2'b01;
    tick(2'b00, 2'b00, 2'b01, 2'b00, "R5 clear");
    idle();

    // self-test with error forcing on interrupt-controller lane
    key(1'b1, 4'hF);
    tick(2'b00, 2'b00, 2'b01, 2'b00, "R9 key accepted");
    idle();
    for (int i = 0; i < 7; i++) tick(2'b00, 2'b00, 2'b01, 2'b00, "R9 running");
    tick(2'b00, 2'b00, 2'b11, 2'b10, "R9 done with fail");

    // self-test paused by debug halt
    key(1'b0, 4'h6);
    tick(2'b00, 2'b00, 2'b10, 2'b10, "R8 restart clears done");
    idle();
    halt = 1'b1;
    for (int i = 0; i < 3; i++) tick(2'b00, 2'b00, 2'b10, 2'b10, "R6 test frozen");
    halt = 1'b0;
    for (int i = 0; i < 7; i++) tick(2'b00, 2'b00, 2'b10, 2'b10, "R6 test resumed");
    tick(2'b00, 2'b00, 2'b11, 2'b10, "R6 R8 done after pause");
    tick(2'b00, 2'b00, 2'b11, 2'b10, "R8 flags held");

    @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule